// File: doc/BRIEF.md
# I2C Slave Address Matcher with Clock-Stretch Wait

This block is the receive-side front end of an I2C slave. It watches the SCL and SDA bus lines after resynchronising them to the system clock. It recognises a START condition and shifts in the address byte. It compares the seven address bits against an own-address register that the host can program. The eighth bit of the address byte is the read/write flag and takes no part in the comparison.

When the address matches, the block pulls SDA low through the ninth clock as an automatic acknowledge. From the falling edge of that ninth clock it holds SCL low and pulses an interrupt. The bus stays parked until the host issues a wait-release. Each data byte that follows is handled the same way: it is acknowledged, latched into a readable register, and followed by the same stretch and interrupt.

When the address does not match, the block stays silent until the next START. A STOP returns it to idle and frees both lines.

Top module: `i2c_addr_wait_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, rx_data is 0 and the own address is 7'h50.
- R2: A START (SDA falling while SCL is high) begins address reception. Bits are sampled on SCL rising edges, MSB first. Bits 7..1 of the received byte form the address and bit 0 (the R/W flag) is excluded from the compare.
- R3: When the received address equals the own address, sda_oe is 1 (SDA pulled low) while SCL is high during the ninth clock.
- R4: After an acknowledged byte, the block asserts scl_oe from the ninth SCL falling edge and keeps it asserted until released. It also pulses irq high for exactly one clock.
- R5: On an address mismatch the block leaves SDA released (NACK), raises no irq and does not assert scl_oe. Bytes that follow are ignored until the next START.
- R6: A one-cycle wait_rel while SCL is held drops scl_oe on the next clock. A wait_rel at any other time has no effect.
- R7: After a matched address, each data byte is acknowledged and stored in rx_data (first received bit in bit 7). It is then followed by the stretch and irq of R4.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with both lines released. A byte clocked without a new START is not acknowledged.
- R9: Asserting own_we loads own_din into the own address, which is used for every later address compare.
- R10: A repeated START in the middle of a data phase restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_we | input | 1 | Load strobe for the own address |
| own_din | input | 7 | New own-address value |
| wait_rel | input | 1 | Host command that ends the clock stretch |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low (open-drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| irq | output | 1 | One-cycle pulse per acknowledged byte |
| rx_data | output | 8 | Last received data byte |

## Verification
The bench sweeps all 128 seven-bit addresses against one own address, and toggles the R/W bit along the way. This catches a compare that includes the flag bit or is off by one bit: such a design would acknowledge the wrong address, or miss the right one. Matched transfers check that SCL stays held until wait_rel arrives, and that the data byte lands in rx_data in bit order. A design that dropped the stretch would let the master run on, and a shift in the wrong direction would return a mirrored byte. A byte sent after a mismatch, a byte sent after STOP, and a repeated START during data are each run to expose a state machine that fails to go quiet or fails to restart.

// File: rtl/i2c_addr_wait_slave.sv
module i2c_addr_wait_slave #(
  parameter int AW = 7,
  parameter logic [AW-1:0] RST_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_we,
  input  logic [AW-1:0] own_din,
  input  logic          wait_rel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq,
  output logic [AW:0]   rx_data
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_ACK, S_WAIT} st_t;
  st_t st;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  logic [BW-1:0] sh;
  logic [CW-1:0] bitcnt;
  logic [AW-1:0] own_addr;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = !scl_q && scl_s;
  wire scl_fall  = scl_q && !scl_s;
  wire start_det = scl_q && scl_s && sda_q && !sda_s;
  wire stop_det  = scl_q && scl_s && !sda_q && sda_s;
  wire byte_done = scl_fall && (bitcnt == CW'(BW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      bitcnt   <= '0;
      own_addr <= RST_ADDR;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      irq      <= 1'b0;
      rx_data  <= '0;
    end else begin
      irq <= 1'b0;
      if (own_we) own_addr <= own_din;
      if (start_det) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (scl_rise) begin
              sh     <= {sh[BW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              if (st == S_DATA) begin
                rx_data <= sh;
                sda_oe  <= 1'b1;
                st      <= S_ACK;
              end else if (sh[BW-1:1] == own_addr) begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b1;
            irq    <= 1'b1;
            st     <= S_WAIT;
          end
          S_WAIT: if (wait_rel) begin
            scl_oe <= 1'b0;
            bitcnt <= '0;
            st     <= S_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4
  AST_IRQ_WITH_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe); // R4
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !wait_rel && !start_det && !stop_det) |=> scl_oe); // R4
  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && wait_rel && !start_det && !stop_det) |=> !scl_oe); // R6
  AST_ACK_NOT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe && scl_oe)); // R3
endmodule

// File: tb/sim_i2c_addr_wait_slave.sv
module sim_i2c_addr_wait_slave;
  localparam int HALF = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic own_we = 1'b0;
  logic [6:0] own_din = '0;
  logic wait_rel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [7:0] rx_data;
  wire scl_ln = scl_m & ~scl_oe;
  wire sda_ln = sda_m & ~sda_oe;
  int checks = 0, errors = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  i2c_addr_wait_slave u0 (
    .clk(clk), .rst_n(rst_n), .own_we(own_we), .own_din(own_din),
    .wait_rel(wait_rel), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .rx_data(rx_data));

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_t();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (scl_ln !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; half_t();
    scl_up(); half_t();
    sda_m = 1'b0; half_t();
    scl_m = 1'b0; half_t();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; half_t();
    scl_up(); half_t();
    sda_m = 1'b1; half_t();
  endtask

  task automatic m_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half_t();
      scl_up(); half_t();
      scl_m = 1'b0; half_t();
    end
    sda_m = 1'b1; half_t();
    scl_up(); half_t();
    acked = (sda_ln == 1'b0);
    scl_m = 1'b0; half_t();
  endtask

  task automatic pulse_rel();
    @(negedge clk) wait_rel = 1'b1;
    @(negedge clk) wait_rel = 1'b0;
  endtask

  task automatic check_addr(input logic [6:0] a, input bit rw, input bit exp, input string req);
    bit ack;
    int c0;
    c0 = irq_cnt;
    m_byte({a, rw}, ack);
    repeat (4) @(negedge clk);
    chk(ack == exp, req, ack, exp);
    chk((irq_cnt - c0) == int'(exp), "R4 irq count", irq_cnt - c0, exp);
    chk(scl_oe == exp, "R4 scl hold", scl_oe, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    int c0;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && irq == 0, "R1 lines", {scl_oe, sda_oe, irq}, 0);
    chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R5 R7: full sweep against the reset own address 7'h50 (R1)
    for (int a = 0; a < 128; a++) begin
      bit exp;
      exp = (a == 'h50);
      d = 8'(a * 29 + 11);
      m_start();
      check_addr(7'(a), a[0], exp, exp ? "R3 ack on match" : "R5 nack on mismatch");
      if (exp) begin
        repeat (20) @(negedge clk);
        chk(scl_oe == 1, "R4 held until release", scl_oe, 1);
        pulse_rel();
        @(negedge clk);
        chk(scl_oe == 0, "R6 released", scl_oe, 0);
        c0 = irq_cnt;
        m_byte(d, ack);
        repeat (4) @(negedge clk);
        chk(ack == 1, "R7 data ack", ack, 1);
        chk(rx_data == d, "R7 rx_data", rx_data, d);
        chk(irq_cnt - c0 == 1, "R7 irq", irq_cnt - c0, 1);
        chk(scl_oe == 1, "R7 stretch", scl_oe, 1);
        pulse_rel();
      end else begin
        c0 = irq_cnt;
        m_byte(d, ack);
        repeat (4) @(negedge clk);
        chk(ack == 0 && irq_cnt == c0 && scl_oe == 0, "R5 ignored byte", ack, 0);
      end
      m_stop();
      repeat (4) @(negedge clk);
      chk(scl_oe == 0 && sda_oe == 0, "R8 stop releases", {scl_oe, sda_oe}, 0);
    end

    // R6: release outside the wait state
    pulse_rel();
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R6 idle release no effect", scl_oe, 0);

    // R8: byte without START after STOP
    c0 = irq_cnt;
    m_byte({7'h50, 1'b0}, ack);
    chk(ack == 0 && irq_cnt == c0, "R8 no start no ack", ack, 0);
    m_stop();

    // R9: reprogram own address
    @(negedge clk) begin own_we = 1'b1; own_din = 7'h2A; end
    @(negedge clk) own_we = 1'b0;
    m_start();
    check_addr(7'h50, 1'b0, 1'b0, "R9 old address rejected");
    m_stop();
    m_start();
    check_addr(7'h2A, 1'b1, 1'b1, "R9 new address accepted");
    pulse_rel();
    m_stop();

    // R10: repeated START during data phase
    m_start();
    check_addr(7'h2A, 1'b0, 1'b1, "R10 first address");
    pulse_rel();
    m_start();
    check_addr(7'h33, 1'b0, 1'b0, "R10 restart mismatch");
    m_start();
    check_addr(7'h2A, 1'b0, 1'b1, "R10 restart match");
    pulse_rel();
    m_byte(8'hC3, ack);
    repeat (4) @(negedge clk);
    chk(ack == 1 && rx_data == 8'hC3, "R10 data after restart", rx_data, 8'hC3);
    pulse_rel();
    m_stop();
    repeat (4) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R8 final stop", scl_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule